// File: doc/BRIEF.md
# Fully Associative TLB Lookup with Protection Checking

This block translates a 32-bit virtual address into a 29-bit physical address. It searches two fully associative tables: a small instruction table (4 entries) and a larger unified table (64 entries). Each entry is a pair of 32-bit words. The high word holds the virtual page and the address-space identifier. The low word holds the physical page and the attribute bits.

The block is given a request with these inputs:
- the address;
- whether the access is an instruction fetch or a data access;
- whether it is a read or a write;
- the privilege level;
- a probe flag.

One cycle later it returns the following:
- a result: fault, read-only or read/write;
- the physical address;
- a cause code;
- an exception strobe.

The block also owns the replacement counter of the unified table, which wraps at a programmable boundary. When an instruction fetch misses the instruction table but hits the unified table, the block copies that entry into an instruction-table slot chosen by a free-running LFSR. Entries are loaded through a write port for each table.

High word layout: virtual page in bits [31:10], identifier in bits [7:0].

Low word layout:
- bit 0: valid
- bit 1: shared
- bit 2: dirty
- bits [4:3]: size
- bits [6:5]: protection
- bits [28:10]: physical page

Top module: `tlb_xlate`

## Requirements
- R1: An entry matches only when its valid bit (low bit 0) is set and the address bits selected by its size mask equal the same bits of the high word. When several entries match, the lowest index wins.
- R2: The size field (low bits [4:3]) selects the mask. Code 0 selects 0xFFFFFC00, code 1 selects 0xFFFFF000, code 2 selects 0xFFFF0000 and code 3 selects 0xFFF00000.
- R3: The identifier compare (high bits [7:0] against the current identifier) is skipped in two cases: when the shared bit (low bit 1) is set, or when the single-space input is high and the request is privileged. Otherwise the two must be equal.
- R4: The physical address is the address bits outside the mask ORed with the low-word bits inside the mask, with bits [31:29] forced to 0.
- R5: An instruction fetch searches the instruction table first and then the unified table. Data accesses search only the unified table. A fetch that hits only in the unified table copies that entry into an instruction-table slot, so later fetches of that page hit even if the unified entry is removed.
- R6: A fetch is treated as a read. A privileged fetch that hits returns read-only (result 1). A user fetch needs protection bit 1 (low bit 6), otherwise it gets a load-protection fault.
- R7: For a privileged data access, protection 0 and 2 are read-only and a write to them faults with store-protection. Protection 1 and 3 are writable.
- R8: For a user data access, protection 0 and 1 fault (load- or store-protection). Protection 2 is read-only, and a write to it faults with store-protection. Protection 3 is writable.
- R9: On a writable page with the dirty bit (low bit 2) clear, a read returns read-only and a write faults with the initial-write code. With the dirty bit set, the result is read/write (result 2).
- R10: The cause codes are: 0 none, 1 load miss, 2 store miss, 3 load protection, 4 store protection, 5 initial write. The result is 0 on every fault. On a fault the physical address is 0.
- R11: Each non-probe request advances the counter by one. The counter goes to 0 instead when the next value would equal the entry count, or would equal a nonzero boundary.
- R12: A probe request never raises the exception strobe and leaves the counter unchanged. The result and cause code are still reported.
- R13: The response appears on the cycle after the request. Reset clears both tables, the counter and the response valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_ifetch | input | 1 | Instruction fetch when high |
| req_write | input | 1 | Write access when high |
| req_priv | input | 1 | Privileged mode |
| req_probe | input | 1 | Probe: no exception, no counter update |
| cur_asid | input | 8 | Current address-space identifier |
| sv_mode | input | 1 | Single-space mode |
| urb | input | 6 | Counter wrap boundary, 0 disables |
| utlb_we | input | 1 | Unified table entry write |
| itlb_we | input | 1 | Instruction table entry write |
| ent_idx | input | 6 | Entry index (low 2 bits for the instruction table) |
| ent_hi | input | 32 | High word to write |
| ent_lo | input | 32 | Low word to write |
| rsp_valid | output | 1 | Response valid |
| rsp_result | output | 2 | 0 fault, 1 read-only, 2 read/write |
| rsp_paddr | output | 32 | Physical address |
| rsp_code | output | 3 | Cause code |
| rsp_exc | output | 1 | Exception raised |
| urc | output | 6 | Replacement counter |

## Verification
The response is registered, so a corrupt entry or a wrong mask shows up on the very next cycle, either as a wrong physical address or as a wrong result and cause code. An ill-placed copy into the instruction table stays hidden until a later fetch to that page. The bench therefore removes the unified-table entry after the copy and fetches again. A counter stepping wrongly shows on the `urc` port one cycle after the request. The bench walks the counter through both the boundary wrap and the full-table wrap.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int NI = 4,
  parameter int NU = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_ifetch,
  input  logic        req_write,
  input  logic        req_priv,
  input  logic        req_probe,
  input  logic [7:0]  cur_asid,
  input  logic        sv_mode,
  input  logic [$clog2(NU)-1:0] urb,
  input  logic        utlb_we,
  input  logic        itlb_we,
  input  logic [$clog2(NU)-1:0] ent_idx,
  input  logic [31:0] ent_hi,
  input  logic [31:0] ent_lo,
  output logic        rsp_valid,
  output logic [1:0]  rsp_result,
  output logic [31:0] rsp_paddr,
  output logic [2:0]  rsp_code,
  output logic        rsp_exc,
  output logic [$clog2(NU)-1:0] urc
);
  localparam int UW = $clog2(NU);
  localparam int IW = (NI > 1) ? $clog2(NI) : 1;
  localparam logic [2:0] C_NONE = 3'd0, C_MISS_LD = 3'd1, C_MISS_ST = 3'd2,
                         C_PROT_LD = 3'd3, C_PROT_ST = 3'd4, C_INIT_WR = 3'd5;
  localparam logic [1:0] RES_FAULT = 2'd0, RES_RO = 2'd1, RES_RW = 2'd2;

  logic [31:0] u_hi [NU];
  logic [31:0] u_lo [NU];
  logic [31:0] i_hi [NI];
  logic [31:0] i_lo [NI];
  logic [7:0]  lfsr;

  function automatic logic [31:0] sz_mask(input logic [1:0] s);
    case (s)
      2'd0:    return 32'hFFFF_FC00;
      2'd1:    return 32'hFFFF_F000;
      2'd2:    return 32'hFFFF_0000;
      default: return 32'hFFF0_0000;
    endcase
  endfunction

  function automatic logic ent_hit(input logic [31:0] hi, input logic [31:0] lo,
                                   input logic [31:0] va, input logic [7:0] asid,
                                   input logic skip);
    return lo[0] && (((hi ^ va) & sz_mask(lo[4:3])) == 32'd0)
           && (lo[1] || skip || hi[7:0] == asid);
  endfunction

  wire skip_asid = sv_mode && req_priv;
  wire wr = req_write && !req_ifetch;

  logic          u_hit, i_hit;
  logic [UW-1:0] u_idx;
  logic [IW-1:0] i_idx;

  always_comb begin
    u_hit = 1'b0;
    u_idx = '0;
    for (int k = NU - 1; k >= 0; k--)
      if (ent_hit(u_hi[k], u_lo[k], req_vaddr, cur_asid, skip_asid)) begin
        u_hit = 1'b1;
        u_idx = UW'(k);
      end
    i_hit = 1'b0;
    i_idx = '0;
    for (int k = NI - 1; k >= 0; k--)
      if (ent_hit(i_hi[k], i_lo[k], req_vaddr, cur_asid, skip_asid)) begin
        i_hit = 1'b1;
        i_idx = IW'(k);
      end
  end

  wire        use_i  = req_ifetch && i_hit;
  wire        any    = use_i || u_hit;
  wire [31:0] sel_lo = use_i ? i_lo[i_idx] : u_lo[u_idx];
  wire [1:0]  pr     = sel_lo[6:5];
  wire        dirty  = sel_lo[2];
  wire [31:0] mask   = sz_mask(sel_lo[4:3]);

  logic [1:0] res;
  logic [2:0] code;
  logic       wable, rable;

  always_comb begin
    res   = RES_FAULT;
    code  = C_NONE;
    wable = req_priv ? pr[0] : (pr == 2'd3);
    rable = req_priv || pr[1];
    if (!any) begin
      code = wr ? C_MISS_ST : C_MISS_LD;
    end else if (req_ifetch) begin
      if (req_priv || pr[1]) res = RES_RO;
      else code = C_PROT_LD;
    end else if (!rable) begin
      code = wr ? C_PROT_ST : C_PROT_LD;
    end else if (wr && !wable) begin
      code = C_PROT_ST;
    end else if (wable && !dirty) begin
      if (wr) code = C_INIT_WR;
      else res = RES_RO;
    end else begin
      res = wable ? RES_RW : RES_RO;
    end
  end

  wire [31:0] paddr = (res == RES_FAULT) ? 32'd0 :
                      ((req_vaddr & ~mask) | (sel_lo & mask & 32'h1FFF_FFFF));

  logic [UW:0]   urc_inc;
  logic [UW-1:0] urc_nxt;
  assign urc_inc = {1'b0, urc} + 1'b1;
  assign urc_nxt = (urc_inc == (UW+1)'(NU) || (urb != '0 && urc_inc == {1'b0, urb}))
                   ? '0 : urc_inc[UW-1:0];

  wire [IW-1:0] cp_slot = IW'(lfsr % NI);
  wire          do_copy = req_valid && req_ifetch && !i_hit && u_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NU; k++) begin
        u_hi[k] <= '0;
        u_lo[k] <= '0;
      end
      for (int k = 0; k < NI; k++) begin
        i_hi[k] <= '0;
        i_lo[k] <= '0;
      end
      lfsr       <= 8'h01;
      urc        <= '0;
      rsp_valid  <= 1'b0;
      rsp_result <= RES_FAULT;
      rsp_paddr  <= '0;
      rsp_code   <= C_NONE;
      rsp_exc    <= 1'b0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (do_copy) begin
        i_hi[cp_slot] <= u_hi[u_idx];
        i_lo[cp_slot] <= u_lo[u_idx];
      end
      if (itlb_we) begin
        i_hi[ent_idx[IW-1:0]] <= ent_hi;
        i_lo[ent_idx[IW-1:0]] <= ent_lo;
      end
      if (utlb_we) begin
        u_hi[ent_idx] <= ent_hi;
        u_lo[ent_idx] <= ent_lo;
      end
      if (req_valid && !req_probe) urc <= urc_nxt;
      rsp_valid  <= req_valid;
      rsp_result <= res;
      rsp_paddr  <= paddr;
      rsp_code   <= code;
      rsp_exc    <= req_valid && !req_probe && (res == RES_FAULT);
    end
  end

  AST_FAULT_PADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_result == RES_FAULT |-> rsp_paddr == 32'd0); // R10
  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_result != 2'd3); // R10
  AST_EXC_IS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_exc |-> rsp_valid && rsp_result == RES_FAULT && rsp_code != C_NONE); // R10
  AST_PROBE_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_probe |=> !rsp_exc); // R12
  AST_PROBE_URC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_probe |=> $stable(urc)); // R12
  AST_URC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_probe |=> (urc == '0 || urc == $past(urc) + 1'b1)); // R11
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R13
  AST_PADDR_29BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_paddr[31:29] == 3'd0); // R4
endmodule

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ifetch, req_write, req_priv, req_probe, sv_mode;
  logic [31:0] req_vaddr;
  logic [7:0] cur_asid;
  logic [5:0] urb, ent_idx, urc;
  logic utlb_we, itlb_we;
  logic [31:0] ent_hi, ent_lo;
  logic rsp_valid, rsp_exc;
  logic [1:0] rsp_result;
  logic [31:0] rsp_paddr;
  logic [2:0] rsp_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ifetch(req_ifetch), .req_write(req_write), .req_priv(req_priv),
    .req_probe(req_probe), .cur_asid(cur_asid), .sv_mode(sv_mode), .urb(urb),
    .utlb_we(utlb_we), .itlb_we(itlb_we), .ent_idx(ent_idx), .ent_hi(ent_hi),
    .ent_lo(ent_lo), .rsp_valid(rsp_valid), .rsp_result(rsp_result),
    .rsp_paddr(rsp_paddr), .rsp_code(rsp_code), .rsp_exc(rsp_exc), .urc(urc));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mklo(input logic [31:0] ppn, input int sz, input int pr,
                                       input bit d, input bit sh, input bit v);
    return (ppn & 32'h1FFF_FC00) | 32'(pr << 5) | 32'(sz << 3) | {29'd0, d, sh, v};
  endfunction

  task automatic wr_ent(input bit itlb, input int idx, input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    utlb_we = !itlb; itlb_we = itlb; ent_idx = 6'(idx); ent_hi = hi; ent_lo = lo;
    @(negedge clk);
    utlb_we = 0; itlb_we = 0;
  endtask

  task automatic acc(input logic [31:0] va, input bit ifetch, input bit w, input bit priv,
                     input bit probe = 0, input logic [7:0] asid = 8'd0, input bit sv = 0);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_ifetch = ifetch; req_write = w;
    req_priv = priv; req_probe = probe; cur_asid = asid; sv_mode = sv;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_rsp(input string tag, input int res, input logic [31:0] pa, input int code);
    chk({tag, " result"}, 32'(rsp_result), 32'(res));
    chk({tag, " paddr"}, rsp_paddr, pa);
    chk({tag, " code"}, 32'(rsp_code), 32'(code));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    chk("R13 rsp_valid after reset", 32'(rsp_valid), 0);
    chk("R13 urc after reset", 32'(urc), 0);
    chk("R13 exc after reset", 32'(rsp_exc), 0);
  endtask

  task automatic t_basic();
    wr_ent(0, 5, 32'h0040_1003, mklo(32'hEABC_D000, 1, 3, 1, 0, 1));
    acc(32'h0040_1234, 0, 0, 1, 0, 8'd3);
    chk("R13 rsp_valid next cycle", 32'(rsp_valid), 1);
    expect_rsp("R4 R1 basic 4K", 2, 32'h0ABC_D234, 0);
  endtask

  task automatic t_sizes();
    wr_ent(0, 30, 32'h4000_0400, mklo(32'h0123_4C00, 0, 3, 1, 1, 1));
    wr_ent(0, 31, 32'h1234_0000, mklo(32'h0765_0000, 2, 3, 1, 1, 1));
    wr_ent(0, 32, 32'h3000_0000, mklo(32'h0500_0000, 3, 3, 1, 1, 1));
    acc(32'h4000_07FF, 0, 0, 1); expect_rsp("R2 1K hit", 2, 32'h0123_4FFF, 0);
    acc(32'h4000_0800, 0, 0, 1); expect_rsp("R2 1K outside", 0, 0, 1);
    acc(32'h1234_ABCD, 0, 0, 1); expect_rsp("R2 64K hit", 2, 32'h0765_ABCD, 0);
    acc(32'h1235_0000, 0, 0, 1); expect_rsp("R2 64K outside", 0, 0, 1);
    acc(32'h300F_FFFF, 0, 0, 1); expect_rsp("R2 1M hit", 2, 32'h050F_FFFF, 0);
    acc(32'h3010_0000, 0, 0, 1); expect_rsp("R2 1M outside", 0, 0, 1);
  endtask

  task automatic t_asid();
    wr_ent(0, 40, 32'h7000_0005, mklo(32'h0011_1000, 1, 3, 1, 0, 1));
    wr_ent(0, 41, 32'h7100_0009, mklo(32'h0022_2000, 1, 3, 1, 1, 1));
    acc(32'h7000_0010, 0, 0, 1, 0, 8'd6, 0); expect_rsp("R3 asid mismatch", 0, 0, 1);
    acc(32'h7000_0010, 0, 0, 1, 0, 8'd6, 1); expect_rsp("R3 sv priv skip", 2, 32'h0011_1010, 0);
    acc(32'h7000_0010, 0, 0, 0, 0, 8'd6, 1); expect_rsp("R3 sv user compares", 0, 0, 1);
    acc(32'h7000_0010, 0, 0, 0, 0, 8'd5, 0); expect_rsp("R3 asid equal", 2, 32'h0011_1010, 0);
    acc(32'h7100_0020, 0, 0, 0, 0, 8'd2, 0); expect_rsp("R3 shared skip", 2, 32'h0022_2020, 0);
  endtask

  task automatic t_priority();
    wr_ent(0, 8,  32'h7200_0000, mklo(32'h0033_3000, 1, 3, 1, 1, 0));
    wr_ent(0, 10, 32'h7200_0000, mklo(32'h0044_4000, 1, 3, 1, 1, 1));
    wr_ent(0, 20, 32'h7200_0000, mklo(32'h0055_5000, 1, 3, 1, 1, 1));
    acc(32'h7200_0008, 0, 0, 1); expect_rsp("R1 lowest valid index", 2, 32'h0044_4008, 0);
  endtask

  task automatic t_prot();
    for (int k = 0; k < 4; k++)
      wr_ent(0, 50 + k, 32'h7400_0000 + 32'(k * 32'h1000), mklo(32'h0060_0000 + 32'(k * 32'h1000), 1, k, 1, 1, 1));
    wr_ent(0, 54, 32'h7400_4000, mklo(32'h0060_4000, 1, 3, 0, 1, 1));
    wr_ent(0, 55, 32'h7400_5000, mklo(32'h0060_5000, 1, 1, 0, 1, 1));
    acc(32'h7400_0004, 0, 0, 1); expect_rsp("R7 priv pr0 read", 1, 32'h0060_0004, 0);
    acc(32'h7400_0004, 0, 1, 1); expect_rsp("R7 priv pr0 write", 0, 0, 4);
    chk("R10 exc on fault", 32'(rsp_exc), 1);
    acc(32'h7400_2004, 0, 1, 1); expect_rsp("R7 priv pr2 write", 0, 0, 4);
    acc(32'h7400_1004, 0, 1, 1); expect_rsp("R7 priv pr1 write", 2, 32'h0060_1004, 0);
    acc(32'h7400_3004, 0, 0, 1); expect_rsp("R7 priv pr3 read", 2, 32'h0060_3004, 0);
    acc(32'h7400_0004, 0, 0, 0); expect_rsp("R8 user pr0 read", 0, 0, 3);
    acc(32'h7400_1004, 0, 0, 0); expect_rsp("R8 user pr1 read", 0, 0, 3);
    acc(32'h7400_1004, 0, 1, 0); expect_rsp("R8 user pr1 write", 0, 0, 4);
    acc(32'h7400_2004, 0, 0, 0); expect_rsp("R8 user pr2 read", 1, 32'h0060_2004, 0);
    acc(32'h7400_2004, 0, 1, 0); expect_rsp("R8 user pr2 write", 0, 0, 4);
    acc(32'h7400_3004, 0, 1, 0); expect_rsp("R8 user pr3 write", 2, 32'h0060_3004, 0);
    acc(32'h7400_4004, 0, 0, 0); expect_rsp("R9 clean read", 1, 32'h0060_4004, 0);
    acc(32'h7400_4004, 0, 1, 0); expect_rsp("R9 clean write user", 0, 0, 5);
    acc(32'h7400_5004, 0, 1, 1); expect_rsp("R9 clean write priv", 0, 0, 5);
    acc(32'h7400_5004, 0, 0, 1); expect_rsp("R9 clean priv read", 1, 32'h0060_5004, 0);
  endtask

  task automatic t_miss();
    acc(32'h7F00_0000, 0, 0, 1); expect_rsp("R10 load miss", 0, 0, 1);
    chk("R10 load miss exc", 32'(rsp_exc), 1);
    acc(32'h7F00_0000, 0, 1, 1); expect_rsp("R10 store miss", 0, 0, 2);
    acc(32'h7E00_0000, 1, 1, 0); expect_rsp("R6 fetch miss is load", 0, 0, 1);
  endtask

  task automatic t_ifetch();
    wr_ent(1, 2, 32'h6000_0000, mklo(32'h0090_0000, 1, 2, 1, 1, 1));
    wr_ent(0, 60, 32'h6000_0000, mklo(32'h00A0_0000, 1, 2, 1, 1, 1));
    acc(32'h6000_0010, 1, 0, 0); expect_rsp("R5 itlb first", 1, 32'h0090_0010, 0);
    acc(32'h6000_0010, 0, 0, 0); expect_rsp("R5 data uses utlb", 1, 32'h00A0_0010, 0);
    wr_ent(0, 61, 32'h6200_0000, mklo(32'h00B0_0000, 1, 2, 0, 1, 1));
    acc(32'h6200_0044, 1, 0, 0); expect_rsp("R5 utlb fetch hit", 1, 32'h00B0_0044, 0);
    wr_ent(0, 61, 32'h6200_0000, 32'd0);
    acc(32'h6200_0044, 1, 0, 0); expect_rsp("R5 copied entry hits", 1, 32'h00B0_0044, 0);
    acc(32'h6200_0044, 0, 0, 0); expect_rsp("R5 data misses removed", 0, 0, 1);
    wr_ent(0, 62, 32'h6300_0000, mklo(32'h00C0_0000, 1, 0, 1, 1, 1));
    acc(32'h6300_0008, 1, 0, 0); expect_rsp("R6 user fetch pr0", 0, 0, 3);
    acc(32'h6300_0008, 1, 0, 1); expect_rsp("R6 priv fetch pr0", 1, 32'h00C0_0008, 0);
  endtask

  task automatic t_counter();
    do_reset();
    t_reset();
    acc(32'h0040_1234, 0, 0, 1, 1, 8'd3);
    expect_rsp("R13 reset clears tables", 0, 0, 1);
    chk("R12 probe no exc", 32'(rsp_exc), 0);
    chk("R12 probe keeps urc", 32'(urc), 0);
    urb = 6'd3;
    acc(0, 0, 0, 1); chk("R11 step 1", 32'(urc), 1);
    acc(0, 0, 0, 1); chk("R11 step 2", 32'(urc), 2);
    acc(0, 0, 0, 1); chk("R11 boundary wrap", 32'(urc), 0);
    acc(0, 0, 0, 1); chk("R11 after wrap", 32'(urc), 1);
    acc(0, 0, 0, 1, 1); chk("R12 probe holds", 32'(urc), 1);
    urb = 6'd0;
    for (int k = 0; k < 62; k++) acc(0, 0, 0, 1);
    chk("R11 reach 63", 32'(urc), 63);
    acc(0, 0, 0, 1); chk("R11 full wrap", 32'(urc), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_vaddr = 0; req_ifetch = 0; req_write = 0;
    req_priv = 0; req_probe = 0; cur_asid = 0; sv_mode = 0; urb = 0;
    utlb_we = 0; itlb_we = 0; ent_idx = 0; ent_hi = 0; ent_lo = 0;
    do_reset();
    t_reset();
    t_basic();
    t_sizes();
    t_asid();
    t_priority();
    t_prot();
    t_miss();
    t_ifetch();
    t_counter();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule